// File: doc/BRIEF.md
# SDRAM Power-up Initialisation Sequencer

This block drives the command pins of a single-data-rate SDRAM from the moment reset is released until the memory can be used. It first holds the device deselected for the 200 µs power-up settle time. It then issues a precharge to all banks and loads the mode register. Eight auto-refresh cycles follow, and the mode register is loaded a second time, because some devices only accept the mode load once they have been refreshed. After that it opens row 0 of bank 0, issues ten throw-away reads to settle the device, and closes the bank again with a precharge-all. Only then does it raise `init_done`.

From that point the block keeps the device refreshed on its own. A refresh timer starts when `init_done` rises. Each time the timer expires, the block issues a group of four auto-refresh commands and holds `ref_req` high, so that the arbiter that owns the pins for normal traffic keeps off the bus. Devices of 128 Mbit or less can live with half the refresh rate. Asserting `slow_refresh` doubles the interval.

All delays given in time units are converted into cycle counts from the clock frequency parameter. The precharge, mode-load, refresh, activate and read-drain gaps are cycle parameters.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, and for PWRUP_NS×CLK_MHZ/1000 cycles after it is released, the device is deselected (cs_n=1, ras_n=1, cas_n=1, we_n=1). During this time `init_done` and `ref_req` are low.
- R2: The first command is precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, with addr[10]=1.
- R3: Mode register load uses all four strobes low, ba=0, and the address word {A9=0 write burst on, A[6:4]=CAS latency, A3=0 sequential, A[2:0]=log2 burst length}, with every other bit 0. The defaults give 0x22. The first load comes exactly T_RP cycles after the first precharge.
- R4: T_MRD cycles after the first mode load, eight auto-refresh commands are issued (cs_n=0, ras_n=0, cas_n=0, we_n=1), spaced T_RFC cycles apart.
- R5: The mode register is loaded again, with the same word, T_RFC cycles after the eighth refresh.
- R6: T_MRD cycles after the second load, the block activates bank 0, row 0 (cs_n=0, ras_n=0, cas_n=1, we_n=1, addr=0). T_RCD cycles later it issues ten reads on consecutive cycles (cs_n=0, ras_n=1, cas_n=0, we_n=1, addr=0 so addr[10]=0, ba=0).
- R7: A precharge-all follows CAS_LAT+BURST_LEN cycles after the last read. `init_done` rises T_RP cycles after that precharge and then stays high until reset.
- R8: In every cycle after the power-up wait in which no command is due, the pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1).
- R9: No refresh is issued after the init sequence until REFI_NS×CLK_MHZ/1000 cycles (P) after `init_done` rises. Each periodic burst is four refreshes spaced T_RFC apart. Consecutive bursts start P cycles apart when `slow_refresh` is low and 2P cycles apart when it is high.
- R10: `ref_req` is high from the first refresh of a periodic burst through the cycle before the burst's fourth T_RFC gap ends (4×T_RFC cycles in total), and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_refresh | input | 1 | Doubles the periodic refresh interval |
| cs_n | output | 1 | SDRAM chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Row/column/mode address |
| ba | output | BANK_W | Bank address |
| ref_req | output | 1 | Periodic refresh burst in progress; arbiter must yield |
| init_done | output | 1 | Initialisation complete |

## Verification
The bench builds the sequencer with CLK_MHZ=10. This shrinks the 200 µs wait to 2000 cycles and the refresh interval to 312 cycles (624 when slow), so the whole init sequence and several periodic bursts fit in a short run. T_RP=3, T_RCD=3 and T_RFC=5 are set apart from T_MRD=2, so a swapped gap would shift a command to a visibly wrong cycle. The bench toggles `slow_refresh` at each burst, which makes the run alternate between short and long intervals and exercises both timer thresholds.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_PRE,
        ST_MRS1,
        ST_REF,
        ST_MRS2,
        ST_ACT,
        ST_RD,
        ST_PRE2,
        ST_GAP,
        ST_RUN
    } seq_state_e;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_PRE,
        CMD_MRS,
        CMD_REF,
        CMD_ACT,
        CMD_RD
    } sdram_cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    // Round a nanosecond duration up to whole clock cycles.
    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Mode word: sequential bursts, write bursts on, CAS latency in [6:4].
    function automatic int unsigned mode_word(int unsigned cl, int unsigned bl);
        int unsigned code;
        code = 0;
        for (int i = 0; i < 4; i++) begin
            if ((1 << i) == bl) code = i;
        end
        return (cl << 4) | code;
    endfunction

    function automatic cmd_pins_t cmd_pins(sdram_cmd_e c);
        case (c)
            CMD_DESEL: return '{1'b1, 1'b1, 1'b1, 1'b1};
            CMD_PRE:   return '{1'b0, 1'b0, 1'b1, 1'b0};
            CMD_MRS:   return '{1'b0, 1'b0, 1'b0, 1'b0};
            CMD_REF:   return '{1'b0, 1'b0, 1'b0, 1'b1};
            CMD_ACT:   return '{1'b0, 1'b0, 1'b1, 1'b1};
            CMD_RD:    return '{1'b0, 1'b1, 1'b0, 1'b1};
            default:   return '{1'b0, 1'b1, 1'b1, 1'b1};
        endcase
    endfunction

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer
    import sdram_init_pkg::*;
#(
    parameter int unsigned REFI_CYC = 3120
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic slow,
    output logic tick
);
    localparam int unsigned TW = $clog2(2 * REFI_CYC + 1);

    logic [TW-1:0] cnt;
    logic [TW-1:0] thr;

    assign thr  = slow ? TW'(2 * REFI_CYC - 1) : TW'(REFI_CYC - 1);
    assign tick = en && (cnt >= thr);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sdram_cmd_encode.sv
module sdram_cmd_encode
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W    = 13,
    parameter int unsigned BANK_W    = 2,
    parameter int unsigned MODE_WORD = 'h22
) (
    input  seq_state_e        state,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba
);
    sdram_cmd_e cmd;
    cmd_pins_t  pins;

    always_comb begin
        addr = '0;
        ba   = '0;
        case (state)
            ST_PWRUP:       cmd = CMD_DESEL;
            ST_PRE, ST_PRE2: begin
                cmd      = CMD_PRE;
                addr[10] = 1'b1;
            end
            ST_MRS1, ST_MRS2: begin
                cmd  = CMD_MRS;
                addr = ADDR_W'(MODE_WORD);
            end
            ST_REF:         cmd = CMD_REF;
            ST_ACT:         cmd = CMD_ACT;
            ST_RD:          cmd = CMD_RD;
            default:        cmd = CMD_NOP;
        endcase
    end

    assign pins  = cmd_pins(cmd);
    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_MHZ    = 100,
    parameter int unsigned PWRUP_NS   = 200000,
    parameter int unsigned REFI_NS    = 31200,
    parameter int unsigned T_RP       = 2,
    parameter int unsigned T_MRD      = 2,
    parameter int unsigned T_RFC      = 7,
    parameter int unsigned T_RCD      = 2,
    parameter int unsigned CAS_LAT    = 2,
    parameter int unsigned BURST_LEN  = 4,
    parameter int unsigned INIT_REFS  = 8,
    parameter int unsigned BURST_REFS = 4,
    parameter int unsigned DUMMY_RDS  = 10,
    parameter int unsigned ADDR_W     = 13,
    parameter int unsigned BANK_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_refresh,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba,
    output logic              ref_req,
    output logic              init_done
);
    localparam int unsigned PW_CYC    = ns_to_cycles(PWRUP_NS, CLK_MHZ);
    localparam int unsigned REFI_CYC  = ns_to_cycles(REFI_NS, CLK_MHZ);
    localparam int unsigned T_DRAIN   = CAS_LAT + BURST_LEN;
    localparam int unsigned MODE_WORD = mode_word(CAS_LAT, BURST_LEN);
    localparam int unsigned GAP_MAX   = max2(max2(T_RP, T_MRD), max2(max2(T_RFC, T_RCD), T_DRAIN));
    localparam int unsigned WCW       = $clog2(max2(PW_CYC, GAP_MAX) + 1);
    localparam int unsigned RCW       = $clog2(max2(max2(INIT_REFS, BURST_REFS), DUMMY_RDS) + 1);

    seq_state_e     state;
    seq_state_e     nxt;
    logic [WCW-1:0] wcnt;
    logic [RCW-1:0] rcnt;
    logic           tick;
    logic           run_idle;

    assign run_idle = (state == ST_RUN);
    assign ref_req  = init_done && !run_idle;

    sdram_refresh_timer #(
        .REFI_CYC (REFI_CYC)
    ) timer_i (
        .clk  (clk),
        .rst  (rst),
        .en   (init_done),
        .slow (slow_refresh),
        .tick (tick)
    );

    sdram_cmd_encode #(
        .ADDR_W    (ADDR_W),
        .BANK_W    (BANK_W),
        .MODE_WORD (MODE_WORD)
    ) enc_i (
        .state (state),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .addr  (addr),
        .ba    (ba)
    );

    // Every command state lasts one cycle, then ST_GAP pads with NOPs so
    // the following command lands exactly GAP cycles later (GAP >= 2).
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_PWRUP;
            nxt       <= ST_PRE;
            wcnt      <= '0;
            rcnt      <= '0;
            init_done <= 1'b0;
        end else begin
            case (state)
                ST_PWRUP: begin
                    if (wcnt == WCW'(PW_CYC - 1)) begin
                        state <= ST_PRE;
                        wcnt  <= '0;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_PRE: begin
                    state <= ST_GAP;
                    wcnt  <= WCW'(T_RP - 1);
                    nxt   <= ST_MRS1;
                end
                ST_MRS1: begin
                    state <= ST_GAP;
                    wcnt  <= WCW'(T_MRD - 1);
                    nxt   <= ST_REF;
                    rcnt  <= RCW'(INIT_REFS);
                end
                ST_REF: begin
                    state <= ST_GAP;
                    wcnt  <= WCW'(T_RFC - 1);
                    rcnt  <= rcnt - 1'b1;
                    if (rcnt != RCW'(1))  nxt <= ST_REF;
                    else if (init_done)   nxt <= ST_RUN;
                    else                  nxt <= ST_MRS2;
                end
                ST_MRS2: begin
                    state <= ST_GAP;
                    wcnt  <= WCW'(T_MRD - 1);
                    nxt   <= ST_ACT;
                end
                ST_ACT: begin
                    state <= ST_GAP;
                    wcnt  <= WCW'(T_RCD - 1);
                    nxt   <= ST_RD;
                    rcnt  <= RCW'(DUMMY_RDS);
                end
                ST_RD: begin
                    rcnt <= rcnt - 1'b1;
                    if (rcnt == RCW'(1)) begin
                        state <= ST_GAP;
                        wcnt  <= WCW'(T_DRAIN - 1);
                        nxt   <= ST_PRE2;
                    end
                end
                ST_PRE2: begin
                    state <= ST_GAP;
                    wcnt  <= WCW'(T_RP - 1);
                    nxt   <= ST_RUN;
                end
                ST_GAP: begin
                    if (wcnt == WCW'(1)) begin
                        state <= nxt;
                        if (nxt == ST_RUN) init_done <= 1'b1;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        state <= ST_REF;
                        rcnt  <= RCW'(BURST_REFS);
                    end
                end
                default: state <= ST_PWRUP;
            endcase
        end
    end
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W    = 13,
    parameter int unsigned BANK_W    = 2,
    parameter int unsigned CAS_LAT   = 2,
    parameter int unsigned BURST_LEN = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BANK_W-1:0] ba,
    input logic              ref_req,
    input logic              init_done,
    input logic              tick,
    input logic              run_idle
);
    localparam int unsigned EXP_MODE = mode_word(CAS_LAT, BURST_LEN);

    // R2
    first_cmd_pre_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (!ras_n && cas_n && !we_n && addr[10]));

    // R3
    mode_word_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && !cas_n && !we_n) |-> (addr == ADDR_W'(EXP_MODE) && ba == '0));

    // R6
    dummy_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && ras_n && !cas_n && we_n) |-> (!addr[10] && ba == '0 && !init_done));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R1
    desel_only_early_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!init_done && !ref_req));

    // R9
    tick_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> run_idle);

    // R10
    refreq_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> init_done);

    // R10
    periodic_ref_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (init_done && !cs_n && !ras_n && !cas_n && we_n) |-> ref_req);
endmodule

bind sdram_init_seq sdram_init_chk #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .CAS_LAT   (CAS_LAT),
    .BURST_LEN (BURST_LEN)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .ba        (ba),
    .ref_req   (ref_req),
    .init_done (init_done),
    .tick      (tick),
    .run_idle  (run_idle)
);

// File: tb/sdram_init_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_init_seq_tb_top;
    localparam int CLK_MHZ   = 10;
    localparam int T_RP      = 3;
    localparam int T_MRD     = 2;
    localparam int T_RFC     = 5;
    localparam int T_RCD     = 3;
    localparam int CAS_LAT   = 2;
    localparam int BURST_LEN = 4;
    localparam int ADDR_W    = 13;
    localparam int BANK_W    = 2;
    localparam int PW        = 200 * CLK_MHZ;
    localparam int P_FAST    = (31200 * CLK_MHZ) / 1000;

    // cmd codes: 0 deselect, 1 nop, 2 precharge, 3 mode load, 4 refresh, 5 activate, 6 read
    typedef struct {
        int    cyc;
        int    cmd;
        int    addr;
        string tag;
    } ev_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              slow_refresh = 1'b0;
    logic              cs_n, ras_n, cas_n, we_n;
    logic [ADDR_W-1:0] addr;
    logic [BANK_W-1:0] ba;
    logic              ref_req, init_done;

    int  vectors = 0;
    int  miscompares = 0;
    bit  finished = 1'b0;
    ev_t q[$];

    always #2.5 clk = ~clk;

    sdram_init_seq #(
        .CLK_MHZ (CLK_MHZ),
        .T_RP    (T_RP),
        .T_MRD   (T_MRD),
        .T_RFC   (T_RFC),
        .T_RCD   (T_RCD),
        .CAS_LAT (CAS_LAT),
        .BURST_LEN (BURST_LEN),
        .ADDR_W  (ADDR_W),
        .BANK_W  (BANK_W)
    ) dut_i (
        .clk          (clk),
        .rst          (rst),
        .slow_refresh (slow_refresh),
        .cs_n         (cs_n),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .addr         (addr),
        .ba           (ba),
        .ref_req      (ref_req),
        .init_done    (init_done)
    );

    function automatic logic [3:0] pins_of(int c);
        case (c)
            0: return 4'b1111;
            2: return 4'b0010;
            3: return 4'b0000;
            4: return 4'b0001;
            5: return 4'b0011;
            6: return 4'b0101;
            default: return 4'b0111;
        endcase
    endfunction

    function automatic void push(int cyc, int cmd, int a, string tag);
        ev_t e;
        e.cyc = cyc; e.cmd = cmd; e.addr = a; e.tag = tag;
        q.push_back(e);
    endfunction

    task automatic compare(int exp_cmd, int exp_addr, bit exp_done, bit exp_req, string tag);
        logic [3:0] got;
        got = {cs_n, ras_n, cas_n, we_n};
        vectors++;
        if (got !== pins_of(exp_cmd)) begin
            miscompares++;
            $display("FAIL %s pins: actual %b expected %b", tag, got, pins_of(exp_cmd));
        end
        if (exp_cmd == 2 && addr[10] !== 1'b1) begin
            miscompares++;
            $display("FAIL %s precharge A10: actual %b expected 1", tag, addr[10]);
        end
        if ((exp_cmd == 3 || exp_cmd == 5 || exp_cmd == 6) &&
            (addr !== ADDR_W'(exp_addr) || ba !== '0)) begin
            miscompares++;
            $display("FAIL %s addr/ba: actual %h/%h expected %h/0", tag, addr, ba, exp_addr);
        end
        if (init_done !== exp_done) begin
            miscompares++;
            $display("FAIL R7 init_done: actual %b expected %b", init_done, exp_done);
        end
        if (ref_req !== exp_req) begin
            miscompares++;
            $display("FAIL R10 ref_req: actual %b expected %b", ref_req, exp_req);
        end
    endtask

    initial begin
        int t, d, next_burst, bs, be, nb, last_end;
        int mode;
        mode = (CAS_LAT << 4) | $clog2(BURST_LEN);

        // Expected init schedule, from the requirements
        t = PW;
        push(t, 2, 1 << 10, "R2");        t += T_RP;
        push(t, 3, mode, "R3");           t += T_MRD;
        for (int i = 0; i < 8; i++) begin
            push(t, 4, 0, "R4");          t += T_RFC;
        end
        push(t, 3, mode, "R5");           t += T_MRD;
        push(t, 5, 0, "R6");              t += T_RCD;
        for (int i = 0; i < 10; i++) begin
            push(t, 6, 0, "R6");          t += 1;
        end
        t = t - 1 + CAS_LAT + BURST_LEN;
        push(t, 2, 1 << 10, "R7");        t += T_RP;
        d = t;
        next_burst = d + P_FAST;
        bs = -1; be = -1; nb = 0;
        last_end = d + 8 * P_FAST;

        // R1: state while reset is held
        repeat (3) @(negedge clk);
        compare(0, 0, 1'b0, 1'b0, "R1");
        repeat (2) @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k <= last_end; k++) begin
            int  ec, ea;
            string tg;
            if (k > 0) @(negedge clk);
            if (k == next_burst) begin
                // R9: periodic burst of four refreshes
                for (int r = 0; r < 4; r++) push(k + r * T_RFC, 4, 0, "R9");
                bs = k; be = k + 4 * T_RFC;
                nb++;
                slow_refresh = nb[0];
                next_burst = k + (slow_refresh ? 2 * P_FAST : P_FAST);
            end
            ec = (k < PW) ? 0 : 1;
            ea = 0;
            tg = (k < PW) ? "R1" : "R8";
            if (q.size() > 0 && q[0].cyc == k) begin
                ev_t e;
                e = q.pop_front();
                ec = e.cmd; ea = e.addr; tg = e.tag;
            end
            compare(ec, ea, k >= d, (k >= bs) && (k < be), tg);
        end

        if (q.size() != 0) begin
            miscompares++;
            $display("FAIL R9 pending refreshes: actual %0d expected 0", q.size());
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(5.0 * 30000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule